// File: doc/BRIEF.md
# Dual-Plan FSK Tone Generator

This block produces the digital carrier for a 300 bit/s binary frequency-shift-keyed transmitter. A 24-bit phase accumulator advances once per output sample by an increment chosen from eight precomputed values. Those values cover two tone plans (the North American 300 baud plan and the ITU 300 baud plan), the originate and answer channel of each, and a mark or space tone within each channel. The top bits of the accumulator address a quarter-wave sine table. The other three quarters of the wave are rebuilt by mirroring the address and negating the result.

Sample timing comes from an internal divider that issues one strobe every `CLK_HZ / SAMPLE_RATE` clocks. The data bit feeds the mark/space select directly, with no scrambling on this path. The plan and channel inputs are sampled only on a strobe clock. Changing a tone alters only the step size and never the accumulator, so the waveform stays phase-continuous across every switch. A downstream filter and DAC consume `sample_o` whenever `sample_vld_o` is high.

Top module: `fsk_tone_gen`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it, `sample_o` is 0, `sample_vld_o` is 0, and the phase accumulator is cleared to 0.
- R2: `sample_vld_o` is high for exactly one clock in every `DIV = CLK_HZ/SAMPLE_RATE` clocks. It first rises on the DIV-th rising edge after reset is released.
- R3: Let p be the top 8 bits of the accumulator before a strobe. The sample issued on that strobe equals round(A·sin(2π(p+0.5)/256)), with rounding to nearest and symmetric in sign, where A = 2^(OUT_W-1)-1. A tolerance of one LSB is allowed.
- R4: On each strobe the accumulator grows by round(f·2^24/SAMPLE_RATE). The tone f is selected by {`plan_i`,`answer_i`,`mark_i`}:
  - 000 gives 1070 Hz and 001 gives 1270 Hz.
  - 010 gives 2025 Hz and 011 gives 2225 Hz.
  - 100 gives 1180 Hz and 101 gives 980 Hz.
  - 110 gives 1850 Hz and 111 gives 1650 Hz.
- R5: A tone change alters only the increment. The accumulator keeps its value across the switch, so the waveform continues without a phase jump.
- R6: The inputs are sampled only on the clock edge that issues a strobe. Changes between strobes have no effect on any output sample. The sampled value sets the phase step from the current sample to the next one.
- R7: The accumulator wraps modulo 2^24 with no saturation.
- R8: Every valid sample lies within [-A, A].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| plan_i | input | 1 | Tone plan: 0 North American 300 baud, 1 ITU 300 baud |
| answer_i | input | 1 | Channel: 0 originate, 1 answer |
| mark_i | input | 1 | Data bit: 1 mark tone, 0 space tone |
| sample_o | output | OUT_W (12) | Signed sine sample |
| sample_vld_o | output | 1 | One-clock strobe marking a new sample |

## Verification
A wrong increment or a disturbed accumulator does not stay hidden. It shifts every later sample's phase, so the first affected strobe already differs from the reference. The difference grows sample by sample rather than fading out. A divider fault moves the strobe itself, which shows up within one sample period. Mid-period input toggling and sign or mirror faults in the quarter-wave rebuild each appear on the first sample that crosses the affected quadrant.

// File: rtl/fsk_tone_gen.sv
module fsk_tone_gen #(
  parameter int CLK_HZ      = 1228800,
  parameter int SAMPLE_RATE = 9600,
  parameter int PHASE_W     = 24,
  parameter int LUT_BITS    = 8,
  parameter int OUT_W       = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    plan_i,
  input  logic                    answer_i,
  input  logic                    mark_i,
  output logic signed [OUT_W-1:0] sample_o,
  output logic                    sample_vld_o
);
  localparam int DIV = CLK_HZ / SAMPLE_RATE;
  localparam int CW  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int QB  = LUT_BITS - 2;
  localparam int QN  = 1 << QB;
  localparam int AMP = (1 << (OUT_W - 1)) - 1;
  localparam longint PI_FP = 64'd843314857;

  function automatic logic [PHASE_W-1:0] step_of(input longint hz);
    longint num;
    num = hz <<< PHASE_W;
    return PHASE_W'((num + longint'(SAMPLE_RATE / 2)) / longint'(SAMPLE_RATE));
  endfunction

  function automatic logic [OUT_W-2:0] quarter_sine(input int q);
    longint x, t, s;
    x = (longint'(2 * q + 1) * PI_FP) / longint'(4 * QN);
    t = x;
    s = x;
    for (int k = 1; k <= 6; k++) begin
      t = (t * x) >>> 28;
      t = (t * x) >>> 28;
      t = -t / longint'((2 * k) * (2 * k + 1));
      s = s + t;
    end
    return (OUT_W-1)'((s * longint'(AMP) + (64'sd1 <<< 27)) >>> 28);
  endfunction

  localparam logic [PHASE_W-1:0] ST_NA_ORG_SPC = step_of(1070);
  localparam logic [PHASE_W-1:0] ST_NA_ORG_MRK = step_of(1270);
  localparam logic [PHASE_W-1:0] ST_NA_ANS_SPC = step_of(2025);
  localparam logic [PHASE_W-1:0] ST_NA_ANS_MRK = step_of(2225);
  localparam logic [PHASE_W-1:0] ST_IT_ORG_SPC = step_of(1180);
  localparam logic [PHASE_W-1:0] ST_IT_ORG_MRK = step_of(980);
  localparam logic [PHASE_W-1:0] ST_IT_ANS_SPC = step_of(1850);
  localparam logic [PHASE_W-1:0] ST_IT_ANS_MRK = step_of(1650);

  logic [OUT_W-2:0] qrom [QN];
  for (genvar g = 0; g < QN; g++) begin : g_rom
    assign qrom[g] = quarter_sine(g);
  end

  logic [CW-1:0]      div_cnt;
  logic               tick;
  logic [PHASE_W-1:0] acc;
  logic [PHASE_W-1:0] step;

  assign tick = (div_cnt == CW'(DIV - 1));

  always_comb begin
    case ({plan_i, answer_i, mark_i})
      3'b000:  step = ST_NA_ORG_SPC;
      3'b001:  step = ST_NA_ORG_MRK;
      3'b010:  step = ST_NA_ANS_SPC;
      3'b011:  step = ST_NA_ANS_MRK;
      3'b100:  step = ST_IT_ORG_SPC;
      3'b101:  step = ST_IT_ORG_MRK;
      3'b110:  step = ST_IT_ANS_SPC;
      default: step = ST_IT_ANS_MRK;
    endcase
  end

  logic [LUT_BITS-1:0]     pidx;
  logic [QB-1:0]           qaddr;
  logic [OUT_W-2:0]        mag;
  logic signed [OUT_W-1:0] wave;

  assign pidx  = acc[PHASE_W-1 -: LUT_BITS];
  assign qaddr = pidx[QB] ? ~pidx[QB-1:0] : pidx[QB-1:0];
  assign mag   = qrom[qaddr];
  assign wave  = pidx[LUT_BITS-1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt      <= '0;
      acc          <= '0;
      sample_o     <= '0;
      sample_vld_o <= 1'b0;
    end else begin
      sample_vld_o <= tick;
      if (tick) begin
        div_cnt  <= '0;
        acc      <= acc + step;
        sample_o <= wave;
      end else begin
        div_cnt  <= div_cnt + 1'b1;
      end
    end
  end

  if (DIV > 1) begin : g_pulse_chk
    assert_vld_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sample_vld_o |=> !sample_vld_o);
  end

  assert_acc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(acc));

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sample_o));

  assert_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld_o |-> (sample_o <= OUT_W'(AMP) && sample_o >= -OUT_W'(AMP)));

  assert_step_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (step != '0 && step[PHASE_W-1] == 1'b0));

endmodule

// File: tb/fsk_tone_gen_test.sv
module fsk_tone_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ = 1228800;
  localparam int SR     = 9600;
  localparam int DIV    = CLK_HZ / SR;
  localparam int OUT_W  = 12;
  localparam int AMP    = (1 << (OUT_W - 1)) - 1;

  logic clk = 0;
  logic rst_n = 0;
  logic plan_i = 0, answer_i = 0, mark_i = 0;
  logic signed [OUT_W-1:0] sample_o;
  logic sample_vld_o;

  int checks = 0, failures = 0;
  string tag = "R4";

  fsk_tone_gen uut (.clk(clk), .rst_n(rst_n), .plan_i(plan_i), .answer_i(answer_i),
                    .mark_i(mark_i), .sample_o(sample_o), .sample_vld_o(sample_vld_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ref_hz(input logic p, input logic a, input logic m);
    if (!p) return a ? (m ? 2225 : 2025) : (m ? 1270 : 1070);
    return a ? (m ? 1650 : 1850) : (m ? 980 : 1180);
  endfunction

  function automatic longint ref_inc(input logic p, input logic a, input logic m);
    real r;
    r = real'(ref_hz(p, a, m)) * 16777216.0 / real'(SR);
    return longint'($rtoi(r + 0.5));
  endfunction

  function automatic int ref_sine(input longint ph);
    real v;
    int p8;
    p8 = int'(ph >> 16);
    v = real'(AMP) * $sin(2.0 * 3.14159265358979 * (real'(p8) + 0.5) / 256.0);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  int     m_cnt = 0;
  longint m_acc = 0;
  bit     m_vld = 0;
  int     m_smp = 0;
  bit     m_wrap = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_acc = 0; m_vld = 0; m_smp = 0; m_wrap = 0;
    end else if (m_cnt == DIV - 1) begin
      longint nxt;
      m_cnt = 0;
      m_vld = 1;
      m_smp = ref_sine(m_acc);
      nxt = m_acc + ref_inc(plan_i, answer_i, mark_i);
      m_wrap = (nxt >= 64'd16777216);
      m_acc = nxt & 64'hFF_FFFF;
    end else begin
      m_cnt++;
      m_vld = 0;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int d;
      check(sample_vld_o == m_vld, "R2 strobe timing", int'(sample_vld_o), int'(m_vld));
      if (m_vld) begin
        d = int'(sample_o) - m_smp;
        check(d <= 1 && d >= -1, $sformatf("R3 sample value (%s%s)", tag, m_wrap ? " R7 wrap" : ""),
              int'(sample_o), m_smp);
        check(int'(sample_o) <= AMP && int'(sample_o) >= -AMP, "R8 range", int'(sample_o), AMP);
      end
    end
  end

  task automatic tone(input logic p, input logic a, input logic m, input int n, input string t);
    @(negedge clk);
    plan_i = p; answer_i = a; mark_i = m; tag = t;
    repeat (n * DIV - 1) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(sample_o == 0, "R1 reset sample", int'(sample_o), 0);
    check(sample_vld_o == 0, "R1 reset strobe", int'(sample_vld_o), 0);
    rst_n = 1;
    for (int i = 0; i < 8; i++)
      tone(i[2], i[1], i[0], 24, "R4 tone plan");
    for (int i = 0; i < 40; i++)
      tone(1'b0, 1'b0, i[0], 1 + (i % 3), "R5 continuity");
    @(negedge clk);
    tag = "R6 mid-period toggling";
    for (int i = 0; i < 1200; i++) begin
      if (i % 37 == 5) mark_i = ~mark_i;
      if (i % 101 == 17) answer_i = ~answer_i;
      if (i % 211 == 3) plan_i = ~plan_i;
      @(negedge clk);
    end
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(sample_o == 0, "R1 mid-run reset sample", int'(sample_o), 0);
    check(sample_vld_o == 0, "R1 mid-run reset strobe", int'(sample_vld_o), 0);
    rst_n = 1;
    tone(1'b1, 1'b1, 1'b1, 30, "R1 restart from zero phase");
    tone(1'b0, 1'b1, 1'b0, 30, "R7 long run");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule